// File: doc/BRIEF.md
# Counter Type Register Access Permission Arbiter

This block decides, in a single combinational pass, what happens to a coprocessor-style read or write aimed at one of the per-counter event-type configuration registers. It takes the access direction, the two encoding fields that select the counter, the current privilege level (0 to 3), and the control bits supplied by each level. From these it selects exactly one outcome: the access goes ahead, it is undefined, it traps to a higher level, or it is unpredictable. When the outcome is a trap, the block also gives the target level and the syndrome code.

The decision is a strictly ordered chain of checks. The first check that matches wins. Which checks take part depends on the privilege level. The two counter-range tests differ: one compares the index with the number of counters the hardware implements, and the other compares it with the number of counters a level-2 supervisor makes accessible. Higher levels are assumed to run in 64-bit mode. The one exception is a level-2 supervisor in 32-bit mode, which only changes the syndrome of the level-0 group-routing trap. The storage of the registers is outside this block.

Top module: `pmx_access_arbiter`

## Requirements
- R1: The counter index is {acc_crm_lo[1:0], acc_op2[2:0]}. An index at or above NUM_CTRS gives undefined when HAS_FGT is 1 and unpredictable when it is 0, at every level. This check takes precedence over all others.
- R2: At levels 0, 1 and 2, when lvl3_pmu_trap and sdd_undef_early are both set, the result is undefined. Only R1 takes precedence over it.
- R3: At level 0, when both usr_en and usr_ext_en are clear, the access traps. The target is level 2 if lvl2_en and grp_route are both set, otherwise level 1. The syndrome is 0x00 only for the level-2 target with lvl2_narrow set; in every other case it is 0x03.
- R4: At level 0, when HAS_FGT is 1 and lvl2_en and fg_en are set, a set fine-grained trap bit traps the access to level 2 with syndrome 0x03. Reads use fg_rd_trap and writes (acc_req_write=1) use fg_wr_trap. The bit for the other direction has no effect.
- R5: At levels 0 and 1, when lvl2_en and lvl2_pmu_trap are both set, the access traps to level 2 with syndrome 0x03.
- R6: At levels 0 and 1, when lvl2_en is set and the index is at or above acc_limit, the access traps to level 2 with syndrome 0x03 if HAS_FGT is 1. If HAS_FGT is 0, the result is unpredictable.
- R7: At levels 0, 1 and 2, a set lvl3_pmu_trap traps the access to level 3 with syndrome 0x03, or gives undefined when sdd_undef is set.
- R8: At level 3, every access whose index passes R1 is allowed. Level 2 ignores the user enables, the fine-grained bits, lvl2_pmu_trap and the accessible limit. When no check matches, the result is allow.
- R9: res_onehot has exactly one bit set: bit 0 allow, bit 1 undefined, bit 2 trap, bit 3 unpredictable. trap_lvl (binary level) and trap_syn are zero unless bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_req_write | input | 1 | 1 for a write access, 0 for a read |
| acc_crm_lo | input | 2 | Upper two bits of the counter index |
| acc_op2 | input | 3 | Lower three bits of the counter index |
| cur_lvl | input | 2 | Privilege level issuing the access |
| usr_en | input | 1 | Level-0 access enable |
| usr_ext_en | input | 1 | Additional level-0 access enable |
| lvl2_en | input | 1 | Level 2 is present and enabled |
| lvl2_narrow | input | 1 | Level 2 runs in 32-bit mode |
| grp_route | input | 1 | Route level-0 exceptions to level 2 |
| fg_en | input | 1 | Level 3 permits fine-grained traps |
| fg_rd_trap | input | 1 | Fine-grained read trap for these registers |
| fg_wr_trap | input | 1 | Fine-grained write trap for these registers |
| lvl2_pmu_trap | input | 1 | Level-2 monitor-register trap |
| lvl3_pmu_trap | input | 1 | Level-3 monitor-register trap |
| sdd_undef_early | input | 1 | Secure-debug-disable gives undefined at top priority |
| sdd_undef | input | 1 | Secure-debug-disable turns the level-3 trap into undefined |
| acc_limit | input | 6 | Number of counters accessible under level 2 |
| res_onehot | output | 4 | One-hot outcome |
| trap_lvl | output | 2 | Target level of a trap |
| trap_syn | output | 8 | Syndrome code of a trap |

## Verification
The hardest outcomes to reach are the late links of the chain. Examples are the accessible-limit trap at level 1, or the level-3 trap at level 0. Each needs every earlier check at that level to stay quiet, while the index sits inside the implemented range and outside the accessible one. The stimulus sweeps all 4096 combinations of the twelve control bits against each level and each direction. It pairs these with index and limit values chosen on both sides of each range boundary, so every link is reached with every combination of earlier links both asserting and staying quiet.

// File: rtl/pmx_pkg.sv
// Package: shared outcome types and syndrome constants for the
// counter-type register access arbiter.
package pmx_pkg;

    // Outcome kind; the numeric value is the bit position in res_onehot.
    typedef enum logic [1:0] {
        VK_ALLOW  = 2'd0,
        VK_UNDEF  = 2'd1,
        VK_TRAP   = 2'd2,
        VK_UNPRED = 2'd3
    } vkind_e;

    typedef struct packed {
        vkind_e      kind;
        logic [1:0]  lvl;
        logic [7:0]  syn;
    } verdict_t;

    localparam logic [7:0] SYN_WIDE   = 8'h03;
    localparam logic [7:0] SYN_GRP_NARROW = 8'h00;

    // Number of ordered checks in the chain.
    localparam int N_STAGES = 7;

    localparam verdict_t V_ALLOW  = '{kind: VK_ALLOW,  lvl: 2'd0, syn: 8'h00};
    localparam verdict_t V_UNDEF  = '{kind: VK_UNDEF,  lvl: 2'd0, syn: 8'h00};
    localparam verdict_t V_UNPRED = '{kind: VK_UNPRED, lvl: 2'd0, syn: 8'h00};
    localparam verdict_t V_TRAP2  = '{kind: VK_TRAP,   lvl: 2'd2, syn: SYN_WIDE};
    localparam verdict_t V_TRAP3  = '{kind: VK_TRAP,   lvl: 2'd3, syn: SYN_WIDE};

endpackage

// File: rtl/pmx_index.sv
// Module: forms the counter index from the two encoding fields and
// compares it against the implemented and the accessible counter counts.
// Assumes the index width is fixed by the encoding (two plus three bits).
module pmx_index #(
    parameter int NUM_CTRS = 31,
    parameter int IDXW     = 5,
    parameter int LIMW     = IDXW + 1
) (
    input  logic [1:0]      crm_lo,
    input  logic [2:0]      op2,
    input  logic [LIMW-1:0] acc_limit,
    output logic [IDXW-1:0] idx,
    output logic            beyond_impl,
    output logic            beyond_acc
);
    localparam logic [LIMW-1:0] IMPL_LIM = LIMW'(NUM_CTRS);

    // Concatenate fields and run both range comparisons.
    always_comb begin
        idx         = {crm_lo, op2};
        beyond_impl = {1'b0, idx} >= IMPL_LIM;
        beyond_acc  = {1'b0, idx} >= acc_limit;
    end
endmodule

// File: rtl/pmx_user_gate.sv
// Module: level-0 user-enable check. Reports a block when no user enable
// is set and picks the trap target and syndrome. Assumes level 1 is
// always 64-bit; only level 2 may be 32-bit.
module pmx_user_gate
    import pmx_pkg::*;
(
    input  logic     usr_en,
    input  logic     usr_ext_en,
    input  logic     lvl2_en,
    input  logic     grp_route,
    input  logic     lvl2_narrow,
    output logic     blocked,
    output verdict_t verdict
);
    // Decide whether level 0 is shut out and where the trap goes.
    always_comb begin
        blocked      = !usr_en && !usr_ext_en;
        verdict.kind = VK_TRAP;
        if (lvl2_en && grp_route) begin
            verdict.lvl = 2'd2;
            verdict.syn = lvl2_narrow ? SYN_GRP_NARROW : SYN_WIDE;
        end else begin
            verdict.lvl = 2'd1;
            verdict.syn = SYN_WIDE;
        end
    end
endmodule

// File: rtl/pmx_stage_eval.sv
// Module: evaluates every check of the ordered chain in parallel, each
// qualified by the set of levels at which it applies. Stage order is the
// priority order; stage 0 is the highest.
module pmx_stage_eval
    import pmx_pkg::*;
#(
    parameter bit HAS_FGT = 1'b1
) (
    input  logic     [1:0] cur_lvl,
    input  logic           is_write,
    input  logic           beyond_impl,
    input  logic           beyond_acc,
    input  logic           usr_blocked,
    input  verdict_t       usr_verdict,
    input  logic           lvl2_en,
    input  logic           fg_en,
    input  logic           fg_rd_trap,
    input  logic           fg_wr_trap,
    input  logic           lvl2_pmu_trap,
    input  logic           lvl3_pmu_trap,
    input  logic           sdd_undef_early,
    input  logic           sdd_undef,
    output logic     [N_STAGES-1:0] hit,
    output verdict_t [N_STAGES-1:0] verd
);
    // Bit i of a mask enables the stage at level i.
    localparam logic [N_STAGES*4-1:0] LVL_MASKS = {
        4'b0111,   // 6: level-3 monitor trap
        4'b0011,   // 5: accessible limit
        4'b0011,   // 4: level-2 monitor trap
        4'b0001,   // 3: fine-grained trap
        4'b0001,   // 2: user enables
        4'b0111,   // 1: early secure-debug undefined
        4'b1111    // 0: implemented limit
    };

    logic [N_STAGES-1:0] raw;
    logic                fg_bit;

    // Raw condition of each stage, before level qualification.
    always_comb begin
        fg_bit  = is_write ? fg_wr_trap : fg_rd_trap;
        raw[0]  = beyond_impl;
        verd[0] = HAS_FGT ? V_UNDEF : V_UNPRED;
        raw[1]  = lvl3_pmu_trap && sdd_undef_early;
        verd[1] = V_UNDEF;
        raw[2]  = usr_blocked;
        verd[2] = usr_verdict;
        raw[3]  = HAS_FGT && lvl2_en && fg_en && fg_bit;
        verd[3] = V_TRAP2;
        raw[4]  = lvl2_en && lvl2_pmu_trap;
        verd[4] = V_TRAP2;
        raw[5]  = lvl2_en && beyond_acc;
        verd[5] = HAS_FGT ? V_TRAP2 : V_UNPRED;
        raw[6]  = lvl3_pmu_trap;
        verd[6] = sdd_undef ? V_UNDEF : V_TRAP3;
    end

    for (genvar s = 0; s < N_STAGES; s++) begin : g_qual
        // Gate each stage by its level mask.
        always_comb hit[s] = raw[s] && LVL_MASKS[s*4 + int'(cur_lvl)];
    end
endmodule

// File: rtl/pmx_prio_pick.sv
// Module: picks the verdict of the lowest-numbered active stage, or allow
// when none is active.
module pmx_prio_pick
    import pmx_pkg::*;
#(
    parameter int N = N_STAGES
) (
    input  logic     [N-1:0] hit,
    input  verdict_t [N-1:0] verd,
    output verdict_t         sel
);
    // Walk from lowest priority upward so the highest priority overwrites.
    always_comb begin
        sel = V_ALLOW;
        for (int s = N - 1; s >= 0; s--) begin
            if (hit[s]) sel = verd[s];
        end
    end
endmodule

// File: rtl/pmx_access_arbiter.sv
// Module: top of the counter-type register access arbiter. Purely
// combinational; higher levels are taken as 64-bit except that level 2
// may be 32-bit for syndrome selection of the level-0 routing trap.
module pmx_access_arbiter
    import pmx_pkg::*;
#(
    parameter int NUM_CTRS = 31,
    parameter bit HAS_FGT  = 1'b1
) (
    input  logic       acc_req_write,
    input  logic [1:0] acc_crm_lo,
    input  logic [2:0] acc_op2,
    input  logic [1:0] cur_lvl,
    input  logic       usr_en,
    input  logic       usr_ext_en,
    input  logic       lvl2_en,
    input  logic       lvl2_narrow,
    input  logic       grp_route,
    input  logic       fg_en,
    input  logic       fg_rd_trap,
    input  logic       fg_wr_trap,
    input  logic       lvl2_pmu_trap,
    input  logic       lvl3_pmu_trap,
    input  logic       sdd_undef_early,
    input  logic       sdd_undef,
    input  logic [5:0] acc_limit,
    output logic [3:0] res_onehot,
    output logic [1:0] trap_lvl,
    output logic [7:0] trap_syn
);
    localparam int IDXW = 5;
    localparam int LIMW = IDXW + 1;

    logic [IDXW-1:0]         idx;
    logic                    beyond_impl;
    logic                    beyond_acc;
    logic                    usr_blocked;
    verdict_t                usr_verdict;
    logic     [N_STAGES-1:0] hit;
    verdict_t [N_STAGES-1:0] verd;
    verdict_t                sel;

    pmx_index #(.NUM_CTRS(NUM_CTRS), .IDXW(IDXW), .LIMW(LIMW)) u_idx (
        .crm_lo      (acc_crm_lo),
        .op2         (acc_op2),
        .acc_limit   (acc_limit),
        .idx         (idx),
        .beyond_impl (beyond_impl),
        .beyond_acc  (beyond_acc)
    );

    pmx_user_gate u_usr (
        .usr_en      (usr_en),
        .usr_ext_en  (usr_ext_en),
        .lvl2_en     (lvl2_en),
        .grp_route   (grp_route),
        .lvl2_narrow (lvl2_narrow),
        .blocked     (usr_blocked),
        .verdict     (usr_verdict)
    );

    pmx_stage_eval #(.HAS_FGT(HAS_FGT)) u_stg (
        .cur_lvl         (cur_lvl),
        .is_write        (acc_req_write),
        .beyond_impl     (beyond_impl),
        .beyond_acc      (beyond_acc),
        .usr_blocked     (usr_blocked),
        .usr_verdict     (usr_verdict),
        .lvl2_en         (lvl2_en),
        .fg_en           (fg_en),
        .fg_rd_trap      (fg_rd_trap),
        .fg_wr_trap      (fg_wr_trap),
        .lvl2_pmu_trap   (lvl2_pmu_trap),
        .lvl3_pmu_trap   (lvl3_pmu_trap),
        .sdd_undef_early (sdd_undef_early),
        .sdd_undef       (sdd_undef),
        .hit             (hit),
        .verd            (verd)
    );

    pmx_prio_pick #(.N(N_STAGES)) u_pick (
        .hit  (hit),
        .verd (verd),
        .sel  (sel)
    );

    // Encode the chosen verdict; trap fields are zero for non-trap outcomes.
    always_comb begin
        res_onehot = 4'b0001 << sel.kind;
        if (sel.kind == VK_TRAP) begin
            trap_lvl = sel.lvl;
            trap_syn = sel.syn;
        end else begin
            trap_lvl = 2'd0;
            trap_syn = 8'h00;
        end
    end

    logic unused_idx;
    always_comb unused_idx = ^idx;
endmodule

// File: rtl/pmx_access_arbiter_chk.sv
// Checker: immediate assertions relating the arbiter's ports; bound to
// every instance of the top module.
module pmx_access_arbiter_chk #(
    parameter int NUM_CTRS = 31,
    parameter bit HAS_FGT  = 1'b1
) (
    input logic [1:0] acc_crm_lo,
    input logic [2:0] acc_op2,
    input logic [1:0] cur_lvl,
    input logic       usr_en,
    input logic       usr_ext_en,
    input logic       lvl2_en,
    input logic       lvl2_narrow,
    input logic       lvl3_pmu_trap,
    input logic       sdd_undef,
    input logic [3:0] res_onehot,
    input logic [1:0] trap_lvl,
    input logic [7:0] trap_syn
);
    logic [5:0] cidx;
    logic       is_trap;

    // Check the outcome against the inputs whenever anything changes.
    always_comb begin
        cidx    = {1'b0, acc_crm_lo, acc_op2};
        is_trap = res_onehot[2];
        a_r9_onehot: assert ($countones(res_onehot) == 1)
            else $error("a_r9_onehot");
        a_r9_quiet: assert (is_trap || (trap_lvl == 2'd0 && trap_syn == 8'h00))
            else $error("a_r9_quiet");
        a_r1_range: assert (!(cidx >= 6'(NUM_CTRS)) ||
                            res_onehot == (HAS_FGT ? 4'b0010 : 4'b1000))
            else $error("a_r1_range");
        a_r8_top_allow: assert (!(cur_lvl == 2'd3 && cidx < 6'(NUM_CTRS)) ||
                                res_onehot == 4'b0001)
            else $error("a_r8_top_allow");
        a_r7_lvl3_cause: assert (!(is_trap && trap_lvl == 2'd3) ||
                                 (lvl3_pmu_trap && !sdd_undef && cur_lvl != 2'd3))
            else $error("a_r7_lvl3_cause");
        a_r3_lvl1_cause: assert (!(is_trap && trap_lvl == 2'd1) ||
                                 (cur_lvl == 2'd0 && !usr_en && !usr_ext_en))
            else $error("a_r3_lvl1_cause");
        a_r3_narrow_syn: assert (!(is_trap && trap_syn == 8'h00) ||
                                 (trap_lvl == 2'd2 && cur_lvl == 2'd0 &&
                                  lvl2_en && lvl2_narrow))
            else $error("a_r3_narrow_syn");
    end
endmodule

bind pmx_access_arbiter pmx_access_arbiter_chk #(
    .NUM_CTRS (NUM_CTRS),
    .HAS_FGT  (HAS_FGT)
) u_chk (
    .acc_crm_lo    (acc_crm_lo),
    .acc_op2       (acc_op2),
    .cur_lvl       (cur_lvl),
    .usr_en        (usr_en),
    .usr_ext_en    (usr_ext_en),
    .lvl2_en       (lvl2_en),
    .lvl2_narrow   (lvl2_narrow),
    .lvl3_pmu_trap (lvl3_pmu_trap),
    .sdd_undef     (sdd_undef),
    .res_onehot    (res_onehot),
    .trap_lvl      (trap_lvl),
    .trap_syn      (trap_syn)
);

// File: tb/sim_pmx_access_arbiter.sv
// Bench: sweeps all control-bit combinations against every level, both
// directions and boundary index/limit values, comparing with a model.
module sim_pmx_access_arbiter;
    localparam int NUM_CTRS = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       wr;
    logic [1:0] crm;
    logic [2:0] op;
    logic [1:0] lvl;
    logic       ue, uxe, l2e, nar, grp, fge, fgr, fgw, l2t, l3t, sde, sdu;
    logic [5:0] lim;
    logic [3:0] res;
    logic [1:0] tl;
    logic [7:0] ts;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pmx_access_arbiter #(.NUM_CTRS(NUM_CTRS), .HAS_FGT(1'b1)) u0 (
        .acc_req_write   (wr),
        .acc_crm_lo      (crm),
        .acc_op2         (op),
        .cur_lvl         (lvl),
        .usr_en          (ue),
        .usr_ext_en      (uxe),
        .lvl2_en         (l2e),
        .lvl2_narrow     (nar),
        .grp_route       (grp),
        .fg_en           (fge),
        .fg_rd_trap      (fgr),
        .fg_wr_trap      (fgw),
        .lvl2_pmu_trap   (l2t),
        .lvl3_pmu_trap   (l3t),
        .sdd_undef_early (sde),
        .sdd_undef       (sdu),
        .acc_limit       (lim),
        .res_onehot      (res),
        .trap_lvl        (tl),
        .trap_syn        (ts)
    );

    // Expected outcome from the requirements; tag names the deciding rule.
    function automatic void model(output logic [3:0] r, output logic [1:0] t,
                                  output logic [7:0] s, output string tag);
        int idx = {crm, op};
        r = 4'b0001; t = 2'd0; s = 8'h00; tag = "R8";
        if (idx >= NUM_CTRS) begin
            r = 4'b0010; tag = "R1";
        end else if (lvl == 2'd3) begin
            r = 4'b0001; tag = "R8";
        end else if (l3t && sde) begin
            r = 4'b0010; tag = "R2";
        end else if (lvl == 2'd0 && !ue && !uxe) begin
            r = 4'b0100; tag = "R3";
            if (l2e && grp) begin t = 2'd2; s = nar ? 8'h00 : 8'h03; end
            else begin t = 2'd1; s = 8'h03; end
        end else if (lvl == 2'd0 && l2e && fge && (wr ? fgw : fgr)) begin
            r = 4'b0100; t = 2'd2; s = 8'h03; tag = "R4";
        end else if (lvl != 2'd2 && l2e && l2t) begin
            r = 4'b0100; t = 2'd2; s = 8'h03; tag = "R5";
        end else if (lvl != 2'd2 && l2e && idx >= int'(lim)) begin
            r = 4'b0100; t = 2'd2; s = 8'h03; tag = "R6";
        end else if (l3t) begin
            tag = "R7";
            if (sdu) r = 4'b0010;
            else begin r = 4'b0100; t = 2'd3; s = 8'h03; end
        end
    endfunction

    // Apply stimulus, wait for it to settle, compare every output (R9 too).
    task automatic check_one();
        logic [3:0] er; logic [1:0] et; logic [7:0] es; string tag;
        #2;
        model(er, et, es, tag);
        checks++;
        if (res !== er || tl !== et || ts !== es) begin
            failures++;
            $display("FAIL %s/R9 lvl=%0d idx=%0d wr=%0d lim=%0d: got res=%b lvl=%0d syn=%h exp res=%b lvl=%0d syn=%h",
                     tag, lvl, {crm, op}, wr, lim, res, tl, ts, er, et, es);
        end
    endtask

    initial begin
        int idx_set [4] = '{0, 7, 30, 31};
        int lim_set [3] = '{0, 8, 31};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 4096; c++) begin
            {ue, uxe, l2e, nar, grp, fge, fgr, fgw, l2t, l3t, sde, sdu} = 12'(c);
            for (int l = 0; l < 4; l++) begin
                lvl = 2'(l);
                for (int i = 0; i < 4; i++) begin
                    {crm, op} = 5'(idx_set[i]);
                    for (int m = 0; m < 3; m++) begin
                        lim = 6'(lim_set[m]);
                        for (int w = 0; w < 2; w++) begin
                            wr = 1'(w);
                            check_one();
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: got running expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule